// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

A watchdog counter that sits behind a small 32-bit register port. A free-running count advances on qualified pulses of a slow tick input. It can run all the time, or only while a core-awake input is high. A selectable right shift turns the count into a 16-bit scaled view. When that view reaches a compare threshold, the block raises a sticky pending flag. It can also clear the count to zero, which gives a repeating interrupt. When enabled, it asks for a system reset.

Every change to the configuration, count, compare or feed register needs a magic unlock value written to the key register first. The unlock covers exactly one protected write. A protected write made while locked does nothing, but it still relocks the block. Software services the watchdog by unlocking and writing the feed code, which clears the count to zero.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads 0, and irq_o and rst_req_o are low. Unmapped offsets always read 0.
- R2: Writing 0x0051F15E to the key register (offset 0x1C) arms the unlock. Writing any other value to it disarms the unlock. The key register reads 1 while armed and 0 otherwise.
- R3: A write to config (0x00), count (0x08), feed (0x18) or compare (0x20) takes effect only while the unlock is armed. Any such write, accepted or not, disarms the unlock.
- R4: An accepted feed write of 0x0D09F00D clears the count to 0. Any other value leaves the count unchanged. The feed register always reads 0.
- R5: The count is 31 bits wide. Bit 31 of a count write is dropped, and bit 31 of a count read is 0.
- R6: The config register keeps all 32 written bits. It holds scale in [3:0], reset-enable at bit 8, zero-on-match at bit 9, run-always at bit 12, run-while-awake at bit 13 and pending at bit 28.
- R7: The scaled view at 0x10 reads (count >> scale) truncated to 16 bits. The compare register keeps the low 16 bits of a write, and its upper bits read 0.
- R8: The count advances by one, wrapping at 31 bits, in each cycle where tick_i is high and the counter runs. The counter runs when run-always is set, or when run-while-awake is set and core_awake_i is high. Otherwise the count holds its value.
- R9: A match is any cycle where the counter runs and the scaled view is at least the compare value. A match sets pending at the next edge. Pending stays set until an accepted config write puts bit 28 to 0. If a match happens in the same cycle as that write, the match wins.
- R10: With zero-on-match set, a match clears the count at the next edge. This overrides the increment. An accepted count write or feed clear still takes priority over it.
- R11: irq_o equals the pending bit. rst_req_o is high in every match cycle while reset-enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_i | input | 1 | Slow tick, one count step per high cycle |
| core_awake_i | input | 1 | Core-awake qualifier for the counter |
| irq_o | output | 1 | Pending interrupt |
| rst_req_o | output | 1 | Reset request during a match |

## Verification
The assertions assume that all inputs are known, with no X or Z, after reset is released. They also assume at most one register access per cycle, with addr_i, we_i and wdata_i held for the whole cycle, and that tick_i and core_awake_i are synchronous to clk_i. The bench drives every input from known values on the falling edge, so these conditions always hold. The random phase mixes correct and wrong key values, writes to unmapped offsets, small compare values and large count loads. Together these reach matches, periodic clears and count wrap-around.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFS_CFG  = 32'h00;
  localparam int unsigned OFS_CNT  = 32'h08;
  localparam int unsigned OFS_SCL  = 32'h10;
  localparam int unsigned OFS_FEED = 32'h18;
  localparam int unsigned OFS_KEY  = 32'h1C;
  localparam int unsigned OFS_CMP  = 32'h20;

  localparam logic [31:0] KEY_MAGIC  = 32'h0051_F15E;
  localparam logic [31:0] FEED_MAGIC = 32'h0D09_F00D;

  localparam int SCALE_W       = 4;
  localparam int CFG_RST_EN    = 8;
  localparam int CFG_ZERO_CMP  = 9;
  localparam int CFG_EN_ALWAYS = 12;
  localparam int CFG_EN_AWAKE  = 13;
  localparam int CFG_PEND      = 28;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic               rst_en;
    logic               zero_cmp;
    logic               en_always;
    logic               en_awake;
    logic               pend;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_key_guard.sv
module wdt_key_guard
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_key_i,
  input  logic              sel_prot_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o,
  output logic              grant_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (wr_i && sel_key_i) armed_q <= (wdata_i == DATA_W'(KEY_MAGIC));
    else if (wr_i && sel_prot_i) armed_q <= 1'b0;  // one-shot, consumed even if useless
  end

  assign armed_o = armed_q;
  assign grant_o = wr_i & sel_prot_i & armed_q;

  AST_KEY_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_key_i && wdata_i == DATA_W'(KEY_MAGIC)) |=> armed_o); // R2
  AST_KEY_BAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_key_i && wdata_i != DATA_W'(KEY_MAGIC)) |=> !armed_o); // R2
  AST_KEY_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_prot_i) |=> !armed_o); // R3
endmodule

// File: rtl/wdt_scaler.sv
module wdt_scaler
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 31,
  parameter int SCALED_W = 16
) (
  input  logic [CNT_W-1:0]    count_i,
  input  logic [SCALE_W-1:0]  scale_i,
  output logic [SCALED_W-1:0] scaled_o
);
  localparam int NUM_TAPS = 1 << SCALE_W;

  logic [SCALED_W-1:0] tap [NUM_TAPS];

  for (genvar s = 0; s < NUM_TAPS; s++) begin : g_tap
    assign tap[s] = SCALED_W'(count_i >> s);
  end

  assign scaled_o = tap[scale_i];
endmodule

// File: rtl/wdt_count_unit.sv
module wdt_count_unit
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 31,
  parameter int SCALED_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_always_i,
  input  logic                en_awake_i,
  input  logic                core_awake_i,
  input  logic                zero_cmp_i,
  input  logic [SCALE_W-1:0]  scale_i,
  input  logic                tick_i,
  input  logic [SCALED_W-1:0] cmp_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_val_i,
  input  logic                feed_clr_i,
  output logic [CNT_W-1:0]    count_o,
  output logic [SCALED_W-1:0] scaled_o,
  output logic                hit_o
);
  logic [CNT_W-1:0] count_q;
  logic             run;

  assign run = en_always_i | (en_awake_i & core_awake_i);

  wdt_scaler #(.CNT_W(CNT_W), .SCALED_W(SCALED_W)) u_scaler (
    .count_i (count_q),
    .scale_i (scale_i),
    .scaled_o(scaled_o)
  );

  assign hit_o = run & (scaled_o >= cmp_i);

  // priority: software load > feed > zero-on-match > tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  count_q <= '0;
    else if (load_i)              count_q <= load_val_i;
    else if (feed_clr_i)          count_q <= '0;
    else if (hit_o && zero_cmp_i) count_q <= '0;
    else if (run && tick_i)       count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !load_i && !feed_clr_i && !(hit_o && zero_cmp_i))
    |=> count_q == CNT_W'($past(count_q) + 1'b1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run && tick_i) && !load_i && !feed_clr_i && !(hit_o && zero_cmp_i))
    |=> $stable(count_q)); // R8
  AST_FEED_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_clr_i && !load_i) |=> count_q == '0); // R4
  AST_ZERO_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && zero_cmp_i && !load_i) |=> count_q == '0); // R10
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 31,
  parameter int SCALED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              core_awake_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CMP_W = SCALED_W;

  logic sel_cfg, sel_cnt, sel_scl, sel_feed, sel_key, sel_cmp, sel_prot;
  logic armed, grant, hit, feed_clr;
  logic [DATA_W-1:0]   cfg_q;
  logic [CMP_W-1:0]    cmp_q;
  logic [CNT_W-1:0]    count;
  logic [SCALED_W-1:0] scaled;
  wdt_ctrl_t           ctrl;

  assign sel_cfg  = (addr_i == ADDR_W'(OFS_CFG));
  assign sel_cnt  = (addr_i == ADDR_W'(OFS_CNT));
  assign sel_scl  = (addr_i == ADDR_W'(OFS_SCL));
  assign sel_feed = (addr_i == ADDR_W'(OFS_FEED));
  assign sel_key  = (addr_i == ADDR_W'(OFS_KEY));
  assign sel_cmp  = (addr_i == ADDR_W'(OFS_CMP));
  assign sel_prot = sel_cfg | sel_cnt | sel_feed | sel_cmp;

  wdt_key_guard #(.DATA_W(DATA_W)) u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (we_i),
    .sel_key_i (sel_key),
    .sel_prot_i(sel_prot),
    .wdata_i   (wdata_i),
    .armed_o   (armed),
    .grant_o   (grant)
  );

  assign ctrl.scale     = cfg_q[SCALE_W-1:0];
  assign ctrl.rst_en    = cfg_q[CFG_RST_EN];
  assign ctrl.zero_cmp  = cfg_q[CFG_ZERO_CMP];
  assign ctrl.en_always = cfg_q[CFG_EN_ALWAYS];
  assign ctrl.en_awake  = cfg_q[CFG_EN_AWAKE];
  assign ctrl.pend      = cfg_q[CFG_PEND];

  // hardware set of pending wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (grant && sel_cfg) begin
      cfg_q           <= wdata_i;
      cfg_q[CFG_PEND] <= wdata_i[CFG_PEND] | hit;
    end else if (hit) begin
      cfg_q[CFG_PEND] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cmp_q <= '0;
    else if (grant && sel_cmp) cmp_q <= wdata_i[CMP_W-1:0];
  end

  assign feed_clr = grant & sel_feed & (wdata_i == DATA_W'(FEED_MAGIC));

  wdt_count_unit #(.CNT_W(CNT_W), .SCALED_W(SCALED_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_always_i (ctrl.en_always),
    .en_awake_i  (ctrl.en_awake),
    .core_awake_i(core_awake_i),
    .zero_cmp_i  (ctrl.zero_cmp),
    .scale_i     (ctrl.scale),
    .tick_i      (tick_i),
    .cmp_i       (cmp_q),
    .load_i      (grant & sel_cnt),
    .load_val_i  (wdata_i[CNT_W-1:0]),
    .feed_clr_i  (feed_clr),
    .count_o     (count),
    .scaled_o    (scaled),
    .hit_o       (hit)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_cfg)      rdata_o = cfg_q;
    else if (sel_cnt) rdata_o = DATA_W'(count);
    else if (sel_scl) rdata_o = DATA_W'(scaled);
    else if (sel_key) rdata_o = DATA_W'(armed);
    else if (sel_cmp) rdata_o = DATA_W'(cmp_q);
  end

  assign irq_o     = ctrl.pend;
  assign rst_req_o = hit & ctrl.rst_en;

  AST_PEND_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> irq_o); // R9
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(grant && sel_cfg)) |=> irq_o); // R9
  AST_LOCKED_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed) |=> $stable(cmp_q)); // R3
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  import wdt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        awake = 1'b0;
  logic        irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;

  always #10 clk = ~clk;

  keyed_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .core_awake_i(awake),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  // reference state built from the requirements
  logic [30:0] m_cnt;
  logic [31:0] m_cfg;
  logic [15:0] m_cmp;
  logic        m_arm;

  function automatic logic m_run();
    return m_cfg[12] | (m_cfg[13] & awake);
  endfunction
  function automatic logic [15:0] m_scaled();
    return 16'(m_cnt >> m_cfg[3:0]);
  endfunction
  function automatic logic m_hit();
    return m_run() & (m_scaled() >= m_cmp);
  endfunction
  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h00:   return m_cfg;
      6'h08:   return {1'b0, m_cnt};
      6'h10:   return {16'h0, m_scaled()};
      6'h1C:   return {31'h0, m_arm};
      6'h20:   return {16'h0, m_cmp};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cfg <= '0; m_cmp <= '0; m_arm <= 1'b0;
    end else begin
      logic prot, ok, h;
      prot = we && (addr == 6'h00 || addr == 6'h08 || addr == 6'h18 || addr == 6'h20);
      ok   = prot && m_arm;
      h    = m_hit();
      if (we && addr == 6'h1C) m_arm <= (wdata == 32'h0051F15E);
      else if (prot)           m_arm <= 1'b0;
      if (ok && addr == 6'h08)                            m_cnt <= wdata[30:0];
      else if (ok && addr == 6'h18 && wdata == 32'h0D09F00D) m_cnt <= '0;
      else if (h && m_cfg[9])                             m_cnt <= '0;
      else if (m_run() && tick)                           m_cnt <= m_cnt + 1'b1;
      if (ok && addr == 6'h00) m_cfg <= wdata | {3'b0, h, 28'h0};
      else if (h)              m_cfg[28] <= 1'b1;
      if (ok && addr == 6'h20) m_cmp <= wdata[15:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_check();
    if (chk_on) begin
      chk("R8 model rdata", rdata, exp_rd(addr));
      chk("R11 model irq_o", {31'h0, irq}, {31'h0, m_cfg[28]});
      chk("R11 model rst_req_o", {31'h0, rst_req}, {31'h0, m_hit() & m_cfg[8]});
    end
  endtask

  task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    model_check();
    we = w; addr = a; wdata = d; tick = t;
  endtask

  task automatic ukw(input logic [5:0] a, input logic [31:0] d);
    step(1'b1, 6'h1C, 32'h0051F15E, 1'b0);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 6'h08, 32'h0, 1'b1);
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, a, 32'h0, 1'b0);
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R1 reset state
    rd_chk(6'h00, 32'h0, "R1 cfg");
    rd_chk(6'h08, 32'h0, "R1 count");
    rd_chk(6'h10, 32'h0, "R1 scaled");
    rd_chk(6'h18, 32'h0, "R1 feed");
    rd_chk(6'h1C, 32'h0, "R1 key");
    rd_chk(6'h20, 32'h0, "R1 cmp");
    rd_chk(6'h04, 32'h0, "R1 unmapped");
    chk("R1 irq_o", {31'h0, irq}, 32'h0);
    chk("R1 rst_req_o", {31'h0, rst_req}, 32'h0);

    // R2 / R3 key behaviour
    step(1'b1, 6'h1C, 32'h0000FFFF, 1'b0);
    rd_chk(6'h1C, 32'h0, "R2 wrong key");
    step(1'b1, 6'h1C, 32'h0051F15E, 1'b0);
    rd_chk(6'h1C, 32'h1, "R2 armed");
    step(1'b1, 6'h18, 32'hAAAAAAAA, 1'b0);
    rd_chk(6'h1C, 32'h0, "R3 consumed by feed");

    // R3 locked write, R5 width, R4 feed
    step(1'b1, 6'h08, 32'h0000BEEF, 1'b0);
    rd_chk(6'h08, 32'h0, "R3 locked count write");
    ukw(6'h08, 32'hAAAAAAAA);
    rd_chk(6'h08, 32'h2AAAAAAA, "R5 count width");
    ukw(6'h18, 32'hAAAAAAAA);
    rd_chk(6'h08, 32'h2AAAAAAA, "R4 wrong feed");
    ukw(6'h18, 32'h0D09F00D);
    rd_chk(6'h08, 32'h0, "R4 feed clears");
    rd_chk(6'h18, 32'h0, "R4 feed reads 0");

    // R7 compare width, R3/R6 config
    ukw(6'h20, 32'h0000BEEF);
    rd_chk(6'h20, 32'h0000BEEF, "R7 cmp");
    ukw(6'h20, 32'h1234ABCD);
    rd_chk(6'h20, 32'h0000ABCD, "R7 cmp width");
    step(1'b1, 6'h00, 32'hFFFFFFFF, 1'b0);
    rd_chk(6'h00, 32'h0, "R3 locked cfg write");
    ukw(6'h00, 32'hFFFFFFFF);
    rd_chk(6'h00, 32'hFFFFFFFF, "R6 cfg all ones");
    chk("R11 irq follows pending", {31'h0, irq}, 32'h1);
    ukw(6'h00, 32'h0);
    rd_chk(6'h00, 32'h0, "R6 cfg cleared");
    chk("R9 pending cleared", {31'h0, irq}, 32'h0);

    // R7 scaled view across all shifts
    ukw(6'h08, 32'h12345678);
    for (int s = 0; s < 16; s++) begin
      ukw(6'h00, 32'(s));
      rd_chk(6'h10, 32'((32'h12345678 >> s) & 32'hFFFF), "R7 scaled");
    end

    // R8 counting, freeze and awake qualifier
    ukw(6'h18, 32'h0D09F00D);
    ukw(6'h20, 32'h0000FFFF);
    ukw(6'h00, 32'h00001000);
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 6'h08, 32'h0, 1'b1);
      step(1'b0, 6'h08, 32'h0, 1'b0);
    end
    rd_chk(6'h08, 32'd10, "R8 run-always");
    ukw(6'h00, 32'h0);
    ticks(5);
    rd_chk(6'h08, 32'd10, "R8 frozen");
    ukw(6'h00, 32'h00002000);
    ticks(5);
    rd_chk(6'h08, 32'd10, "R8 core asleep");
    awake = 1'b1;
    ticks(3);
    rd_chk(6'h08, 32'd13, "R8 core awake");
    awake = 1'b0;

    // R9 / R11 match, sticky pending, set wins over clear
    ukw(6'h20, 32'd20);
    ukw(6'h00, 32'h00001100);
    ticks(6);
    rd_chk(6'h08, 32'd19, "R8 before match");
    chk("R9 no pending yet", {31'h0, irq}, 32'h0);
    ticks(1);
    rd_chk(6'h10, 32'd20, "R7 at match");
    chk("R11 rst_req_o on match", {31'h0, rst_req}, 32'h1);
    rd_chk(6'h08, 32'd20, "R10 no clear when off");
    chk("R9 pending set", {31'h0, irq}, 32'h1);
    ukw(6'h00, 32'h00001100);
    rd_chk(6'h00, 32'h10001100, "R9 match wins over clear");
    ukw(6'h20, 32'h0000FFFF);
    ukw(6'h00, 32'h00001000);
    rd_chk(6'h00, 32'h00001000, "R9 clear accepted");
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    // R10 periodic clear
    ukw(6'h00, 32'h0);
    ukw(6'h18, 32'h0D09F00D);
    ukw(6'h20, 32'd3);
    ukw(6'h00, 32'h00001200);
    ticks(10);
    rd_chk(6'h08, 32'd2, "R10 periodic wrap");
    chk("R10 periodic irq", {31'h0, irq}, 32'h1);
    ukw(6'h00, 32'h0);

    // constrained random against the reference state
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom % 8;
      case (pick)
        0: a = 6'h00; 1: a = 6'h08; 2: a = 6'h10; 3: a = 6'h18;
        4, 5: a = 6'h1C; 6: a = 6'h20; default: a = 6'h04;
      endcase
      r = $urandom;
      d = r;
      if (a == 6'h1C && ($urandom % 10) < 7) d = 32'h0051F15E;
      if (a == 6'h18 && ($urandom % 2) == 0) d = 32'h0D09F00D;
      if (a == 6'h20) d = r % 64;
      if (a == 6'h08 && ($urandom % 4) == 0) d = 32'h7FFFFFF0 | (r & 32'hF);
      awake = 1'($urandom % 2);
      step(1'($urandom % 4 != 0), a, d, 1'($urandom % 2));
    end
    step(1'b0, 6'h00, 32'h0, 1'b0);
    step(1'b0, 6'h08, 32'h0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule